// File: doc/BRIEF.md
# Spike-Timing Plasticity Weight Updater

This block adjusts the strengths of N synapses that feed one postsynaptic neuron, using a pair-based exponential spike-timing rule. For every presynaptic input and for the postsynaptic neuron it keeps a saturating count of simulation steps since the last spike. Spike pulses are collected between steps. On each accepted time-step strobe the counts advance, and a sweep walks the synapses in ascending order, one per clock. When the postsynaptic neuron fired, every synapse is strengthened by a term that decays with the time since its own last presynaptic spike. Otherwise only the synapses whose input fired are weakened, by a term that decays with the time since the last postsynaptic spike.

The weights sit in an external memory. The block reads it through a synchronous read port with one cycle of latency and writes it back through a separate write port. Both decay curves come from one shared magnitude unit. Each curve halves every 2^k steps and is zero beyond a fixed window. A written weight is always held within [0, W_MAX]. Spike generation and synaptic current computation belong to other blocks.

Top module: `stdp_updater`

## Requirements
- R1: After reset busy_o and wr_en_o are low, and every input and the postsynaptic neuron count as never having spiked, so a first postsynaptic step writes all weights back unchanged.
- R2: A step strobe accepted while idle with at least one pending event raises busy_o for exactly N+1 cycles, starting the cycle after the strobe. During this time rd_addr_o presents 0, 1, ..., N-1 in successive cycles, and the write for a synapse occurs one cycle after its read.
- R3: When the postsynaptic neuron fired in the step, each synapse is written with w + (A_PLUS >> (dt >> HALF_PLUS_LOG2)), where dt is the number of steps since its last presynaptic spike (0 when both fired in the same step). The added term is 0 when dt >= WINDOW.
- R4: When the postsynaptic neuron did not fire, only synapses whose input fired are written, with w - (A_MINUS >> (dt >> HALF_MINUS_LOG2)), where dt is the number of steps since the last postsynaptic spike. The term is 0 when dt >= WINDOW. No other address is written.
- R5: A synapse whose input fires in the same step as the postsynaptic neuron is potentiated with dt = 0 and not depressed.
- R6: Every written weight lies in [0, W_MAX]. Potentiation saturates at W_MAX and depression stops at 0.
- R7: Step counts advance by one on every accepted strobe, including strobes with no events. They restart at 0 on a spike and saturate at 2^AGE_W-1, and a saturated count gives a zero change.
- R8: Spike pulses that arrive during a sweep, or between strobes, are held and applied at the next accepted strobe. A strobe that arrives while busy_o is high is ignored: it does not advance the counts and does not restart the sweep.
- R9: An accepted strobe with no pending event starts no sweep: busy_o stays low and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One-cycle time-step strobe |
| pre_spike_i | input | N | Presynaptic spike pulses, one bit per synapse |
| post_spike_i | input | 1 | Postsynaptic spike pulse |
| busy_o | output | 1 | High while a sweep runs |
| rd_addr_o | output | $clog2(N) | Weight memory read address |
| rd_data_i | input | W_W | Weight read data, one cycle after the address |
| wr_en_o | output | 1 | Weight memory write enable |
| wr_addr_o | output | $clog2(N) | Weight memory write address |
| wr_data_o | output | W_W | Updated weight |

## Verification
A step count that went wrong, for example by wrapping, freezing, or advancing on an ignored strobe, shows up at the next postsynaptic or presynaptic step. It appears as a weight off by one decay level, so the bench compares every memory word after every sweep against an arithmetic model. A mishandled pending event shows as a missing or extra sweep, or as a wrong write count within N+1 cycles of the next strobe. An off-by-one in the sweep counter shows in the same sweep as a wrong busy length or a read address out of order.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    typedef enum logic {
        UPD_LTP = 1'b0,
        UPD_LTD = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/stdp_age_bank.sv
module stdp_age_bank #(
    parameter int N     = 16,
    parameter int AGE_W = 5
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       adv_i,
    input  logic [N-1:0]               spk_i,
    output logic [N-1:0][AGE_W-1:0]    age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef logic [N-1:0][AGE_W-1:0] ages_t;

    ages_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (adv_i) begin
            for (int i = 0; i < N; i++) begin
                if (spk_i[i]) begin
                    age_d[i] = '0;
                end else if (age_q[i] != AGE_MAX) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= AGE_MAX;
            end
        end else begin
            age_q <= age_d;
        end
    end

    assign age_o = age_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r7_age_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
            adv_i && spk_i[g] |=> age_o[g] == '0);
        a_r7_age_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !adv_i |=> $stable(age_o[g]));
        a_r7_age_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
            adv_i && !spk_i[g] && age_o[g] == AGE_MAX |=> age_o[g] == AGE_MAX);
    end

endmodule

// File: rtl/stdp_decay.sv
module stdp_decay
    import stdp_pkg::*;
#(
    parameter int AGE_W           = 5,
    parameter int MAG_W           = 8,
    parameter int WINDOW          = 16,
    parameter int A_PLUS          = 32,
    parameter int A_MINUS         = 24,
    parameter int HALF_PLUS_LOG2  = 2,
    parameter int HALF_MINUS_LOG2 = 3
) (
    input  logic [AGE_W-1:0] dt_i,
    input  upd_mode_e        mode_i,
    output logic [MAG_W-1:0] mag_o
);

    localparam int IDX_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [MAG_W-1:0] tab_ltp [WINDOW];
    logic [MAG_W-1:0] tab_ltd [WINDOW];
    logic [IDX_W-1:0] idx;

    for (genvar k = 0; k < WINDOW; k++) begin : g_tab
        localparam int LtpVal = A_PLUS >> (k >> HALF_PLUS_LOG2);
        localparam int LtdVal = A_MINUS >> (k >> HALF_MINUS_LOG2);
        assign tab_ltp[k] = LtpVal[MAG_W-1:0];
        assign tab_ltd[k] = LtdVal[MAG_W-1:0];
    end

    assign idx = dt_i[IDX_W-1:0];

    always_comb begin
        mag_o = '0;
        if (int'(dt_i) < WINDOW) begin
            mag_o = (mode_i == UPD_LTP) ? tab_ltp[idx] : tab_ltd[idx];
        end
    end

    // R3 and R4: outside the window the decay term vanishes
    always_comb begin
        a_r3_window_cutoff: assert (int'(dt_i) < WINDOW || mag_o == '0);
    end

endmodule

// File: rtl/stdp_weight_alu.sv
module stdp_weight_alu
    import stdp_pkg::*;
#(
    parameter int W_W   = 8,
    parameter int W_MAX = 200
) (
    input  logic [W_W-1:0] w_i,
    input  logic [W_W-1:0] mag_i,
    input  upd_mode_e      mode_i,
    output logic [W_W-1:0] w_o
);

    localparam logic [W_W:0] CEIL = (W_W+1)'(W_MAX);

    logic [W_W:0] sum;

    always_comb begin
        sum = '0;
        if (mode_i == UPD_LTP) begin
            sum = {1'b0, w_i} + {1'b0, mag_i};
        end else if (mag_i < w_i) begin
            sum = {1'b0, w_i} - {1'b0, mag_i};
        end
        w_o = (sum > CEIL) ? CEIL[W_W-1:0] : sum[W_W-1:0];
    end

    always_comb begin
        a_r6_alu_range: assert (w_o <= CEIL[W_W-1:0]);
    end

endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
    import stdp_pkg::*;
#(
    parameter int N               = 16,
    parameter int AGE_W           = 5,
    parameter int W_W             = 8,
    parameter int W_MAX           = 200,
    parameter int WINDOW          = 16,
    parameter int A_PLUS          = 32,
    parameter int A_MINUS         = 24,
    parameter int HALF_PLUS_LOG2  = 2,
    parameter int HALF_MINUS_LOG2 = 3,
    localparam int AW             = $clog2(N)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           step_i,
    input  logic [N-1:0]   pre_spike_i,
    input  logic           post_spike_i,
    output logic           busy_o,
    output logic [AW-1:0]  rd_addr_o,
    input  logic [W_W-1:0] rd_data_i,
    output logic           wr_en_o,
    output logic [AW-1:0]  wr_addr_o,
    output logic [W_W-1:0] wr_data_o
);

    localparam int CNT_W = $clog2(N + 1);
    localparam logic [AW-1:0] LAST = AW'(N - 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(N);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [AW-1:0]    widx;
        logic             post_mode;
        logic [N-1:0]     work_pre;
        logic [N-1:0]     pend_pre;
        logic             pend_post;
    } state_t;

    state_t s_d, s_q;

    logic                       accept;
    logic [N-1:0]               ev_pre;
    logic                       ev_post;
    logic [N-1:0][AGE_W-1:0]    pre_age;
    logic [0:0][AGE_W-1:0]      post_age;
    logic [AGE_W-1:0]           slot_dt;
    upd_mode_e                  slot_mode;
    logic [W_W-1:0]             slot_mag;
    logic                       slot_ev;

    always_comb begin
        s_d     = s_q;
        accept  = step_i && !s_q.busy;
        ev_pre  = s_q.pend_pre | pre_spike_i;
        ev_post = s_q.pend_post | post_spike_i;

        if (accept) begin
            s_d.pend_pre  = '0;
            s_d.pend_post = 1'b0;
            if (ev_post || (|ev_pre)) begin
                s_d.busy      = 1'b1;
                s_d.cnt       = '0;
                s_d.vld       = 1'b0;
                s_d.post_mode = ev_post;
                s_d.work_pre  = ev_pre;
            end
        end else begin
            s_d.pend_pre  = ev_pre;
            s_d.pend_post = ev_post;
        end

        if (s_q.busy) begin
            s_d.vld = 1'b0;
            if (s_q.cnt < CNT_END) begin
                s_d.vld  = 1'b1;
                s_d.widx = s_q.cnt[AW-1:0];
                s_d.cnt  = s_q.cnt + 1'b1;
            end
            if (s_q.vld && s_q.widx == LAST) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    stdp_age_bank #(
        .N     (N),
        .AGE_W (AGE_W)
    ) i_pre_ages (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (accept),
        .spk_i  (ev_pre),
        .age_o  (pre_age)
    );

    stdp_age_bank #(
        .N     (1),
        .AGE_W (AGE_W)
    ) i_post_age (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (accept),
        .spk_i  (ev_post),
        .age_o  (post_age)
    );

    always_comb begin
        if (s_q.post_mode) begin
            slot_dt   = pre_age[s_q.widx];
            slot_mode = UPD_LTP;
            slot_ev   = 1'b1;
        end else begin
            slot_dt   = post_age[0];
            slot_mode = UPD_LTD;
            slot_ev   = s_q.work_pre[s_q.widx];
        end
    end

    stdp_decay #(
        .AGE_W           (AGE_W),
        .MAG_W           (W_W),
        .WINDOW          (WINDOW),
        .A_PLUS          (A_PLUS),
        .A_MINUS         (A_MINUS),
        .HALF_PLUS_LOG2  (HALF_PLUS_LOG2),
        .HALF_MINUS_LOG2 (HALF_MINUS_LOG2)
    ) i_decay (
        .dt_i   (slot_dt),
        .mode_i (slot_mode),
        .mag_o  (slot_mag)
    );

    stdp_weight_alu #(
        .W_W   (W_W),
        .W_MAX (W_MAX)
    ) i_alu (
        .w_i    (rd_data_i),
        .mag_i  (slot_mag),
        .mode_i (slot_mode),
        .w_o    (wr_data_o)
    );

    assign busy_o    = s_q.busy;
    assign rd_addr_o = s_q.cnt[AW-1:0];
    assign wr_en_o   = s_q.vld && slot_ev;
    assign wr_addr_o = s_q.widx;

    a_r2_write_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> busy_o);
    a_r2_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.vld && $past(s_q.vld) |-> s_q.widx == $past(s_q.widx) + 1'b1);
    a_r2_sweep_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(s_q.vld && s_q.widx == LAST));
    a_r9_start_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(step_i));
    a_r6_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> wr_data_o <= W_W'(W_MAX));
    a_r4_ltd_not_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o && !s_q.post_mode |-> wr_data_o <= rd_data_i);
    a_r3_ltp_not_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o && s_q.post_mode && rd_data_i <= W_W'(W_MAX) |-> wr_data_o >= rd_data_i);

endmodule

// File: tb/test_stdp_updater.sv
module test_stdp_updater;

    localparam int N       = 16;
    localparam int AGE_W   = 5;
    localparam int W_W     = 8;
    localparam int W_MAX   = 200;
    localparam int WINDOW  = 16;
    localparam int A_PLUS  = 32;
    localparam int A_MINUS = 24;
    localparam int HPL     = 2;
    localparam int HMI     = 3;
    localparam int AW      = $clog2(N);
    localparam int AGE_MAX = (1 << AGE_W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           step = 1'b0;
    logic [N-1:0]   pre_spike = '0;
    logic           post_spike = 1'b0;
    logic           busy;
    logic [AW-1:0]  rd_addr;
    logic [W_W-1:0] rd_data;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [W_W-1:0] wr_data;

    logic [W_W-1:0] mem [N];
    int wr_cnt;

    int checks = 0;
    int fails = 0;

    int ref_w [N];
    int ref_pre_age [N];
    int ref_post_age;
    logic [N-1:0] ref_pend_pre;
    logic ref_pend_post;

    always #10 clk = ~clk;

    stdp_updater #(
        .N (N), .AGE_W (AGE_W), .W_W (W_W), .W_MAX (W_MAX), .WINDOW (WINDOW),
        .A_PLUS (A_PLUS), .A_MINUS (A_MINUS),
        .HALF_PLUS_LOG2 (HPL), .HALF_MINUS_LOG2 (HMI)
    ) i_stdp_updater (
        .clk_i (clk), .rst_ni (rst_n), .step_i (step),
        .pre_spike_i (pre_spike), .post_spike_i (post_spike),
        .busy_o (busy), .rd_addr_o (rd_addr), .rd_data_i (rd_data),
        .wr_en_o (wr_en), .wr_addr_o (wr_addr), .wr_data_o (wr_data)
    );

    function automatic int init_w(int i);
        return (i * 53 + 7) % (W_MAX + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= W_W'(init_w(i));
            rd_data <= '0;
            wr_cnt  <= 0;
        end else begin
            rd_data <= mem[rd_addr];
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    function automatic int ltp_mag(int dt);
        return (dt < WINDOW) ? (A_PLUS >> (dt >> HPL)) : 0;
    endfunction

    function automatic int ltd_mag(int dt);
        return (dt < WINDOW) ? (A_MINUS >> (dt >> HMI)) : 0;
    endfunction

    function automatic logic [N-1:0] pat(int d);
        return N'(d * 40503 ^ 23130);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ref_reset();
        for (int i = 0; i < N; i++) begin
            ref_w[i] = init_w(i);
            ref_pre_age[i] = AGE_MAX;
        end
        ref_post_age  = AGE_MAX;
        ref_pend_pre  = '0;
        ref_pend_post = 1'b0;
    endtask

    task automatic ref_accept(input logic [N-1:0] pre, input logic post,
                              output bit swept, output int nwr);
        logic [N-1:0] ep;
        logic eq;
        ep = ref_pend_pre | pre;
        eq = ref_pend_post | post;
        ref_pend_pre = '0;
        ref_pend_post = 1'b0;
        for (int i = 0; i < N; i++)
            ref_pre_age[i] = ep[i] ? 0 : ((ref_pre_age[i] < AGE_MAX) ? ref_pre_age[i] + 1 : AGE_MAX);
        ref_post_age = eq ? 0 : ((ref_post_age < AGE_MAX) ? ref_post_age + 1 : AGE_MAX);
        swept = eq || (|ep);
        nwr = 0;
        for (int i = 0; i < N; i++) begin
            if (eq) begin
                ref_w[i] = ref_w[i] + ltp_mag(ref_pre_age[i]);
                if (ref_w[i] > W_MAX) ref_w[i] = W_MAX;
                nwr++;
            end else if (ep[i]) begin
                ref_w[i] = ref_w[i] - ltd_mag(ref_post_age);
                if (ref_w[i] < 0) ref_w[i] = 0;
                nwr++;
            end
        end
    endtask

    task automatic compare_mem(input string tag);
        for (int i = 0; i < N; i++)
            check(int'(mem[i]) == ref_w[i], tag, int'(mem[i]), ref_w[i]);
    endtask

    task automatic run_step(input logic [N-1:0] pre, input logic post,
                            input bit inj, input logic [N-1:0] ipre, input logic ipost,
                            input string tag);
        bit swept;
        int nwr;
        int w0;
        int c;
        int bad;
        @(negedge clk);
        pre_spike = pre;
        post_spike = post;
        step = 1'b1;
        w0 = wr_cnt;
        ref_accept(pre, post, swept, nwr);
        @(negedge clk);
        pre_spike = '0;
        post_spike = 1'b0;
        step = 1'b0;
        if (!swept) begin
            check(busy == 1'b0, "R9 no sweep on empty step", int'(busy), 0);
            @(negedge clk);
            check(wr_cnt == w0, "R9 no write on empty step", wr_cnt - w0, 0);
            return;
        end
        c = 0;
        bad = 0;
        while (busy && c < N + 8) begin
            if (c < N && int'(rd_addr) != c) bad++;
            if (inj && c == 2) begin
                pre_spike = ipre;
                post_spike = ipost;
                step = 1'b1;
                ref_pend_pre = ref_pend_pre | ipre;
                ref_pend_post = ref_pend_post | ipost;
            end else begin
                pre_spike = '0;
                post_spike = 1'b0;
                step = 1'b0;
            end
            @(negedge clk);
            c++;
        end
        pre_spike = '0;
        post_spike = 1'b0;
        step = 1'b0;
        check(c == N + 1, "R2 busy length", c, N + 1);
        check(bad == 0, "R2 read address order", bad, 0);
        check(wr_cnt - w0 == nwr, "R4 write count", wr_cnt - w0, nwr);
        compare_mem(tag);
    endtask

    task automatic empty_steps(input int n);
        for (int k = 0; k < n; k++) run_step('0, 1'b0, 1'b0, '0, 1'b0, "R9 empty");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        ref_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(wr_en == 1'b0, "R1 write enable after reset", int'(wr_en), 0);
        compare_mem("R1 memory after reset");

        // R1 / R7: never-spiked inputs give zero potentiation
        run_step('0, 1'b1, 1'b0, '0, 1'b0, "R1 first post step unchanged");

        // R3: potentiation over all delays
        for (int d = 0; d < 19; d++) begin
            run_step(pat(d), 1'b0, 1'b0, '0, 1'b0, "R4 pre step");
            empty_steps(d);
            run_step('0, 1'b1, 1'b0, '0, 1'b0, "R3 potentiation by delay");
        end

        // R4: depression over all delays
        for (int d = 0; d < 19; d++) begin
            run_step('0, 1'b1, 1'b0, '0, 1'b0, "R3 post step");
            empty_steps(d);
            run_step(pat(d + 7), 1'b0, 1'b0, '0, 1'b0, "R4 depression by delay");
        end

        // R5: coincident spikes
        for (int d = 0; d < 4; d++)
            run_step(pat(d + 31), 1'b1, 1'b0, '0, 1'b0, "R5 coincident pre and post");

        // R6: saturate upward, then drain to zero
        for (int d = 0; d < 10; d++)
            run_step('1, 1'b1, 1'b0, '0, 1'b0, "R6 upper clamp");
        for (int i = 0; i < N; i++)
            check(int'(mem[i]) == W_MAX, "R6 all weights at ceiling", int'(mem[i]), W_MAX);
        for (int d = 0; d < 16; d++)
            run_step('1, 1'b0, 1'b0, '0, 1'b0, "R6 lower clamp");
        for (int i = 0; i < N; i++)
            check(int'(mem[i]) == 0, "R6 all weights at floor", int'(mem[i]), 0);

        // rebuild some weight for later cases
        for (int d = 0; d < 4; d++)
            run_step('1, 1'b1, 1'b0, '0, 1'b0, "R5 refill");

        // R8: spikes and strobe during a sweep
        run_step('0, 1'b1, 1'b1, 16'h00F0, 1'b0, "R8 sweep with held spikes");
        run_step('0, 1'b0, 1'b0, '0, 1'b0, "R8 held spikes applied");
        run_step(16'h0003, 1'b0, 1'b1, 16'h0100, 1'b1, "R8 sweep with held post");
        run_step('0, 1'b0, 1'b0, '0, 1'b0, "R8 held post applied");

        // R7: post count saturates, later pre spikes change nothing
        empty_steps(40);
        run_step(16'hA5A5, 1'b0, 1'b0, '0, 1'b0, "R7 saturated post count");
        empty_steps(40);
        run_step('0, 1'b1, 1'b0, '0, 1'b0, "R7 saturated pre counts");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule